// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block keeps wall-clock time and calendar date as seven packed-BCD fields: seconds, minutes, hours (24-hour), day of week, day of month, month and a two-digit year. Each single-cycle pulse on `tick` advances the time by one second. Carries pass from field to field. The day of month wraps according to the length of the current month, and February follows a leap-year rule that is correct for the years 2000 through 2099.

Software or a host sets the clock with a parallel load that writes all seven fields in one cycle. A stop input freezes the count; it is normally driven from an oscillator stop flag. All fields are always visible on the outputs. Deriving the one-per-second tick from a crystal and any bus access wrapper lie outside this block.

Top module: `bcd_calendar_counter`

## Requirements
- R1: After reset the outputs read 00:00:00, day of week 01, date 01, month 01, year 00. Every field is an 8-bit packed BCD value, with the tens digit in bits [7:4] and the units digit in bits [3:0].
- R2: Seconds and minutes count 00 to 59 in BCD. A tick advances seconds by one. Seconds wrapping from 59 to 00 advances minutes in the same cycle, and minutes wrapping from 59 to 00 advances hours.
- R3: Hours count 00 to 23. Wrapping from 23 to 00 advances both the date and the day of week.
- R4: Day of week counts 01 to 07 and then returns to 01, independent of the date.
- R5: April, June, September and November (BCD 04, 06, 09, 11) wrap the date after 30. The other months except February wrap after 31. A date wrap returns the date to 01 and advances the month.
- R6: February wraps after 29 in a leap year and after 28 otherwise. A year is leap when its BCD value is a multiple of four: the tens digit is even and the units digit is 0, 4 or 8, or the tens digit is odd and the units digit is 2 or 6. Year 00 is leap.
- R7: Month wraps from 12 to 01 and advances the year. Year wraps from 99 to 00. A tick at 23:59:59 on 31 December of year 99 yields 00:00:00 on 01 January of year 00.
- R8: While `load` is high, the next clock edge writes every field from the load inputs. This takes priority over a tick in the same cycle.
- R9: While `stop` is high, ticks are ignored and all fields hold. A load still takes effect.
- R10: In a cycle with no tick and no load, all fields hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse once per second |
| stop | input | 1 | Freeze counting (oscillator stopped) |
| load | input | 1 | Parallel load strobe |
| set_sec | input | 8 | BCD seconds to load |
| set_min | input | 8 | BCD minutes to load |
| set_hour | input | 8 | BCD hours to load |
| set_dow | input | 8 | BCD day of week to load |
| set_date | input | 8 | BCD date to load |
| set_month | input | 8 | BCD month to load |
| set_year | input | 8 | BCD year to load |
| cur_sec | output | 8 | BCD seconds |
| cur_min | output | 8 | BCD minutes |
| cur_hour | output | 8 | BCD hours |
| cur_dow | output | 8 | BCD day of week |
| cur_date | output | 8 | BCD date |
| cur_month | output | 8 | BCD month |
| cur_year | output | 8 | BCD year |

## Verification
Two kinds of event can land on the same clock edge.

The first is a tick together with a load. The bench raises both in one cycle, and the outputs must then show exactly the loaded values with no one-second step applied on top.

The second is a tick together with a stop. Here every field must stay unchanged, including when the seconds sit at 59 and a tick would otherwise ripple up through the calendar.

Random sequences mix all three inputs from states close to month and year boundaries. Each result is judged against an integer-arithmetic calendar model in the bench.

// File: rtl/cal_pkg.sv
package cal_pkg;
   localparam int DIGIT_W = 4;
   localparam int FIELD_W = 2 * DIGIT_W;

   typedef logic [FIELD_W-1:0] bcd2_t;

   // Increment a two-digit BCD value by one (no range wrap).
   function automatic bcd2_t bcd_inc(input bcd2_t v);
      bcd2_t r;
      if (v[DIGIT_W-1:0] == DIGIT_W'(9)) begin
         r[DIGIT_W-1:0]       = '0;
         r[FIELD_W-1:DIGIT_W] = v[FIELD_W-1:DIGIT_W] + DIGIT_W'(1);
      end else begin
         r[DIGIT_W-1:0]       = v[DIGIT_W-1:0] + DIGIT_W'(1);
         r[FIELD_W-1:DIGIT_W] = v[FIELD_W-1:DIGIT_W];
      end
      return r;
   endfunction
endpackage

// File: rtl/cal_bcd2_counter.sv
module cal_bcd2_counter
   import cal_pkg::*;
#(
   parameter bcd2_t LOW = 8'h00
)(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  load,
   input  bcd2_t load_val,
   input  logic  inc,
   input  bcd2_t last,
   output bcd2_t value,
   output logic  carry
);
   generate
      if (LOW[DIGIT_W-1:0] > 4'd9 || LOW[FIELD_W-1:DIGIT_W] > 4'd9) begin : g_bad_low
         $error("LOW must be a valid BCD value");
      end
   endgenerate

   assign carry = inc && (value == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      value <= LOW;
      else if (load)   value <= load_val;
      else if (inc)    value <= carry ? LOW : bcd_inc(value);
   end

   p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !inc) |=> $stable(value));

   p_wrap_to_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (carry && !load) |=> (value == LOW));
endmodule

// File: rtl/cal_month_len.sv
module cal_month_len
   import cal_pkg::*;
#(
   parameter bit CENTURY_LEAP = 1'b1
)(
   input  bcd2_t month,
   input  bcd2_t year,
   output bcd2_t last_date
);
   logic [DIGIT_W-1:0] units;
   logic               div4;
   logic               leap;

   assign units = year[DIGIT_W-1:0];

   always_comb begin
      if (year[DIGIT_W])
         div4 = (units == 4'd2) || (units == 4'd6);
      else
         div4 = (units == 4'd0) || (units == 4'd4) || (units == 4'd8);
   end

   generate
      if (CENTURY_LEAP) begin : g_zero_leap
         assign leap = div4;
      end else begin : g_zero_common
         assign leap = div4 && (year != '0);
      end
   endgenerate

   always_comb begin
      unique case (month)
         8'h02:                      last_date = leap ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: last_date = 8'h30;
         default:                    last_date = 8'h31;
      endcase
   end
endmodule

// File: rtl/bcd_calendar_counter.sv
module bcd_calendar_counter
   import cal_pkg::*;
#(
   parameter bit CENTURY_LEAP = 1'b1
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       stop,
   input  logic       load,
   input  logic [7:0] set_sec,
   input  logic [7:0] set_min,
   input  logic [7:0] set_hour,
   input  logic [7:0] set_dow,
   input  logic [7:0] set_date,
   input  logic [7:0] set_month,
   input  logic [7:0] set_year,
   output logic [7:0] cur_sec,
   output logic [7:0] cur_min,
   output logic [7:0] cur_hour,
   output logic [7:0] cur_dow,
   output logic [7:0] cur_date,
   output logic [7:0] cur_month,
   output logic [7:0] cur_year
);
   logic  advance;
   logic  c_sec, c_min, c_hour, c_dow, c_date, c_month, c_year;
   bcd2_t last_date;

   assign advance = tick && !stop && !load;

   cal_bcd2_counter #(.LOW(8'h00)) u_sec (
      .clk(clk), .rst_n(rst_n), .load(load), .load_val(set_sec),
      .inc(advance), .last(8'h59), .value(cur_sec), .carry(c_sec));

   cal_bcd2_counter #(.LOW(8'h00)) u_min (
      .clk(clk), .rst_n(rst_n), .load(load), .load_val(set_min),
      .inc(c_sec), .last(8'h59), .value(cur_min), .carry(c_min));

   cal_bcd2_counter #(.LOW(8'h00)) u_hour (
      .clk(clk), .rst_n(rst_n), .load(load), .load_val(set_hour),
      .inc(c_min), .last(8'h23), .value(cur_hour), .carry(c_hour));

   cal_bcd2_counter #(.LOW(8'h01)) u_dow (
      .clk(clk), .rst_n(rst_n), .load(load), .load_val(set_dow),
      .inc(c_hour), .last(8'h07), .value(cur_dow), .carry(c_dow));

   cal_month_len #(.CENTURY_LEAP(CENTURY_LEAP)) u_mlen (
      .month(cur_month), .year(cur_year), .last_date(last_date));

   cal_bcd2_counter #(.LOW(8'h01)) u_date (
      .clk(clk), .rst_n(rst_n), .load(load), .load_val(set_date),
      .inc(c_hour), .last(last_date), .value(cur_date), .carry(c_date));

   cal_bcd2_counter #(.LOW(8'h01)) u_month (
      .clk(clk), .rst_n(rst_n), .load(load), .load_val(set_month),
      .inc(c_date), .last(8'h12), .value(cur_month), .carry(c_month));

   cal_bcd2_counter #(.LOW(8'h00)) u_year (
      .clk(clk), .rst_n(rst_n), .load(load), .load_val(set_year),
      .inc(c_month), .last(8'h99), .value(cur_year), .carry(c_year));

   p_load_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cur_sec == $past(set_sec) && cur_min == $past(set_min) &&
                cur_hour == $past(set_hour) && cur_dow == $past(set_dow) &&
                cur_date == $past(set_date) && cur_month == $past(set_month) &&
                cur_year == $past(set_year)));

   p_stop_freezes_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (stop && !load) |=> $stable({cur_sec, cur_min, cur_hour, cur_dow,
                                   cur_date, cur_month, cur_year}));

   p_date_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (c_date && !load) |=> (cur_date == 8'h01 && cur_hour == 8'h00));

   p_year_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (c_year && !load) |=> (cur_year == 8'h00 && cur_month == 8'h01));
endmodule

// File: tb/bcd_calendar_counter_tb.sv
module bcd_calendar_counter_tb;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0, stop = 1'b0, load = 1'b0;
   logic [7:0] set_sec = '0, set_min = '0, set_hour = '0, set_dow = '0;
   logic [7:0] set_date = '0, set_month = '0, set_year = '0;
   logic [7:0] cur_sec, cur_min, cur_hour, cur_dow, cur_date, cur_month, cur_year;

   int n_checks = 0;
   int n_fail   = 0;
   int es, em, eh, ew, ed, emo, ey;   // expected model, integers

   always #(CLK_PERIOD/2) clk = ~clk;

   bcd_calendar_counter u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .stop(stop), .load(load),
      .set_sec(set_sec), .set_min(set_min), .set_hour(set_hour), .set_dow(set_dow),
      .set_date(set_date), .set_month(set_month), .set_year(set_year),
      .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour), .cur_dow(cur_dow),
      .cur_date(cur_date), .cur_month(cur_month), .cur_year(cur_year));

   function automatic logic [7:0] to_bcd(input int v);
      return 8'(((v / 10) << 4) | (v % 10));
   endfunction

   function automatic int from_bcd(input logic [7:0] b);
      return int'(b[7:4]) * 10 + int'(b[3:0]);
   endfunction

   function automatic int days_in(input int mo, input int y);
      if (mo == 2) return (y % 4 == 0) ? 29 : 28;
      if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
      return 31;
   endfunction

   task automatic model_edge();
      if (load) begin
         es = from_bcd(set_sec);  em = from_bcd(set_min); eh = from_bcd(set_hour);
         ew = from_bcd(set_dow);  ed = from_bcd(set_date);
         emo = from_bcd(set_month); ey = from_bcd(set_year);
      end else if (tick && !stop) begin
         es++;
         if (es == 60) begin
            es = 0; em++;
            if (em == 60) begin
               em = 0; eh++;
               if (eh == 24) begin
                  eh = 0;
                  ew = (ew == 7) ? 1 : ew + 1;
                  ed++;
                  if (ed > days_in(emo, ey)) begin
                     ed = 1; emo++;
                     if (emo == 13) begin
                        emo = 1; ey = (ey + 1) % 100;
                     end
                  end
               end
            end
         end
      end
   endtask

   task automatic check(input string tag);
      logic [55:0] act, exp;
      act = {cur_year, cur_month, cur_date, cur_dow, cur_hour, cur_min, cur_sec};
      exp = {to_bcd(ey), to_bcd(emo), to_bcd(ed), to_bcd(ew), to_bcd(eh), to_bcd(em), to_bcd(es)};
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual y/mo/d/w/h/m/s=%h expected=%h", tag, act, exp);
      end
   endtask

   // Drive at negedge, model at posedge, compare at next negedge.
   task automatic step(input logic t, input logic s, input logic l, input string tag);
      tick = t; stop = s; load = l;
      @(posedge clk);
      model_edge();
      @(negedge clk);
      tick = 1'b0; stop = 1'b0; load = 1'b0;
      check(tag);
   endtask

   task automatic set_vals(input int y, input int mo, input int d, input int w,
                           input int h, input int m, input int s);
      set_year = to_bcd(y); set_month = to_bcd(mo); set_date = to_bcd(d);
      set_dow = to_bcd(w); set_hour = to_bcd(h); set_min = to_bcd(m); set_sec = to_bcd(s);
   endtask

   task automatic set_random_near_edge();
      int y, mo, d;
      y  = int'($urandom % 100);
      mo = 1 + int'($urandom % 12);
      d  = days_in(mo, y) - int'($urandom % 2);
      set_vals(y, mo, d, 1 + int'($urandom % 7),
               ($urandom % 2) ? 23 : int'($urandom % 24),
               ($urandom % 2) ? 59 : int'($urandom % 60),
               55 + int'($urandom % 5));
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240));
      es = 0; em = 0; eh = 0; ew = 1; ed = 1; emo = 1; ey = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset state");

      step(1'b0, 1'b0, 1'b0, "R10 idle hold");
      step(1'b1, 1'b0, 1'b0, "R2 single tick");

      set_vals(24, 3, 15, 3, 10, 0, 59);
      step(1'b0, 1'b0, 1'b1, "R8 load");
      step(1'b1, 1'b0, 1'b0, "R2 seconds wrap");

      set_vals(24, 3, 15, 3, 10, 59, 59);
      step(1'b1, 1'b0, 1'b1, "R8 load beats tick");
      step(1'b1, 1'b1, 1'b0, "R9 stop at :59");
      step(1'b0, 1'b0, 1'b0, "R10 hold");
      step(1'b1, 1'b0, 1'b0, "R2 minute wrap");

      set_vals(24, 3, 15, 7, 23, 59, 59);
      step(1'b0, 1'b0, 1'b1, "R8 load");
      step(1'b1, 1'b0, 1'b0, "R3 R4 hour wrap dow 7->1");

      set_vals(24, 4, 30, 2, 23, 59, 59);
      step(1'b0, 1'b0, 1'b1, "R8 load");
      step(1'b1, 1'b0, 1'b0, "R5 April 30 wrap");

      set_vals(24, 1, 30, 2, 23, 59, 59);
      step(1'b0, 1'b0, 1'b1, "R8 load");
      step(1'b1, 1'b0, 1'b0, "R5 January 30 no wrap");

      set_vals(24, 2, 28, 2, 23, 59, 59);
      step(1'b0, 1'b0, 1'b1, "R8 load");
      step(1'b1, 1'b0, 1'b0, "R6 leap Feb 28->29");
      set_vals(23, 2, 28, 2, 23, 59, 59);
      step(1'b0, 1'b0, 1'b1, "R8 load");
      step(1'b1, 1'b0, 1'b0, "R6 common Feb 28->Mar 1");
      set_vals(0, 2, 29, 2, 23, 59, 59);
      step(1'b0, 1'b0, 1'b1, "R8 load");
      step(1'b1, 1'b0, 1'b0, "R6 year 00 Feb 29 wrap");
      set_vals(12, 2, 28, 2, 23, 59, 59);
      step(1'b0, 1'b0, 1'b1, "R8 load");
      step(1'b1, 1'b0, 1'b0, "R6 odd-tens leap year 12");

      set_vals(99, 12, 31, 7, 23, 59, 59);
      step(1'b0, 1'b0, 1'b1, "R8 load");
      step(1'b1, 1'b1, 1'b0, "R9 stop at full rollover");
      step(1'b1, 1'b0, 1'b0, "R7 full rollover");

      for (int sc = 0; sc < 60; sc++) begin
         set_random_near_edge();
         step(1'b0, 1'b0, 1'b1, "R8 random load");
         for (int k = 0; k < 16; k++) begin
            int r;
            r = int'($urandom % 100);
            if (r < 4) set_random_near_edge();
            step(r < 75, (r >= 75 && r < 90), r < 4, "R2 R5 R6 R7 R9 random");
         end
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule